// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational N-bit adder. The operands are split into 4-bit slices. Inside each slice every bit forms its own generate term (both operand bits set) and its own propagate term (either operand bit set). All four carries of the slice are written as flat sum-of-products expressions of these terms and the slice's incoming carry, so they are available after one AND-OR depth rather than rippling bit by bit.

Each slice also reduces its bits to one slice generate and one slice propagate. A second lookahead stage applies the same flat equations to these pairs and the external carry-in. It delivers the carry entering every slice above the lowest, and the final carry-out.

The block has no clock and no state. A datapath instantiates it with its chosen width, which must be a multiple of four, and reads `sum` and `cout` in the same cycle as the operands.

Top module: `cla_adder`

## Requirements
- R1: For every pair of operands and carry-in, `sum` equals the low WIDTH bits of `a + b + cin`.
- R2: `cout` equals bit WIDTH of `a + b + cin`. This holds for the extremes: all-ones plus all-ones with carry-in 1 gives all-ones and carry-out 1, and zero plus zero with carry-in 1 gives 1 and carry-out 0.
- R3: A carry created in the top bit of slice k (bit 4k+3 set in both operands) arrives in slice k+1, so the sum has only bit 4k+4 set. A carry-in of 1 added to all-ones plus zero travels through every slice, giving sum 0 and carry-out 1.
- R4: When every bit position has exactly one operand bit set (`a ^ b` all ones), `sum` is all ones if `cin` is 0 and all zeros if `cin` is 1, and `cout` equals `cin`. Alternating patterns 1010... plus 0101... are one such case.
- R5: The block is exact at any WIDTH that is a multiple of four. At WIDTH = 8 it is correct for all 2^17 input combinations.
- R6: Zero plus zero with carry-in 0 gives sum 0 and carry-out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The hardest cases are at the slice boundaries. The bench therefore places a generated carry in the top bit of each slice in turn. A missing or misplaced term in the second-level equations would drop that carry or deliver it to the wrong slice. Operands whose bits all propagate, including the alternating patterns and all-ones plus zero, force a carry-in to travel the whole width; a wrong slice propagate product would break the chain there. An 8-bit instance is swept over every input, so any wrong term in the in-slice equations shows up as a wrong sum bit. A 16-bit instance gets the corner values and random operands.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned SLICE_W = 4;

  // Flat carries of one 4-bit slice: bit i of the result is the carry into bit i+1.
  function automatic logic [3:0] slice_carries(input logic [3:0] g, input logic [3:0] p,
                                               input logic c0);
    logic [3:0] c;
    c[0] = g[0] | (p[0] & c0);
    c[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c0);
    c[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c0);
    c[3] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])
         | (p[3] & p[2] & p[1] & p[0] & c0);
    return c;
  endfunction

  // Slice generate (bit 1) and slice propagate (bit 0).
  function automatic logic [1:0] slice_gp(input logic [3:0] g, input logic [3:0] p);
    logic sg;
    logic sp;
    sp = p[0] & p[1] & p[2] & p[3];
    sg = g[3] | (g[2] & p[3]) | (g[1] & p[2] & p[3]) | (g[0] & p[1] & p[2] & p[3]);
    return {sg, sp};
  endfunction

endpackage

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
(
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] sum,
  output logic       slice_g,
  output logic       slice_p,
  output logic       slice_cout
);

  logic [3:0] bit_g;
  logic [3:0] bit_p;
  logic [3:0] carries;
  logic [3:0] carry_in_vec;

  assign bit_g        = a & b;
  assign bit_p        = a | b;
  assign carries      = slice_carries(bit_g, bit_p, cin);
  assign carry_in_vec = {carries[2:0], cin};
  assign sum          = a ^ b ^ carry_in_vec;
  assign {slice_g, slice_p} = slice_gp(bit_g, bit_p);
  assign slice_cout   = carries[3];

  // The flat carry-out must agree with the slice generate/propagate summary.
  always_comb begin
    p_slice_summary_r3: assert (slice_cout == (slice_g | (slice_p & cin)))
      else $error("slice carry-out disagrees with slice generate/propagate");
  end

  // Slice result equals plain arithmetic on its four bits.
  always_comb begin
    p_slice_sum_r1: assert ({slice_cout, sum} == ({1'b0, a} + {1'b0, b} + {4'b0, cin}))
      else $error("slice sum wrong");
  end

endmodule

// File: rtl/cla_upper.sv
module cla_upper #(
  parameter int unsigned NSLICE = 4
) (
  input  logic [NSLICE-1:0] sg,
  input  logic [NSLICE-1:0] sp,
  input  logic              cin,
  output logic [NSLICE:0]   carry
);

  assign carry[0] = cin;

  // Carry into slice j as one flat sum of products over the slices below it.
  for (genvar j = 1; j <= NSLICE; j++) begin : g_carry
    always_comb begin
      logic acc;
      logic term;
      acc  = 1'b0;
      for (int k = 0; k < j; k++) begin
        term = sg[k];
        for (int m = k + 1; m < j; m++) term = term & sp[m];
        acc = acc | term;
      end
      term = cin;
      for (int m = 0; m < j; m++) term = term & sp[m];
      carry[j] = acc | term;
    end
  end

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int unsigned NSLICE = WIDTH / cla_pkg::SLICE_W;

  logic [NSLICE-1:0] sg;
  logic [NSLICE-1:0] sp;
  logic [NSLICE-1:0] local_cout;
  logic [NSLICE:0]   carry;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    cla_slice u_slice (
      .a          (a[4*s +: 4]),
      .b          (b[4*s +: 4]),
      .cin        (carry[s]),
      .sum        (sum[4*s +: 4]),
      .slice_g    (sg[s]),
      .slice_p    (sp[s]),
      .slice_cout (local_cout[s])
    );

    // Second-level carry into the next slice must match this slice's own flat carry-out.
    always_comb begin
      p_boundary_r3: assert (carry[s+1] == local_cout[s])
        else $error("lookahead carry at slice boundary %0d mismatches", s);
    end
  end

  cla_upper #(.NSLICE(NSLICE)) u_upper (
    .sg    (sg),
    .sp    (sp),
    .cin   (cin),
    .carry (carry)
  );

  assign cout = carry[NSLICE];

  always_comb begin
    p_cout_match_r2: assert (cout == local_cout[NSLICE-1])
      else $error("carry-out differs from top slice carry");
  end

  // Full-propagate case: carry-in passes straight through.
  always_comb begin
    if ((a ^ b) == {WIDTH{1'b1}}) begin
      p_fullprop_r4: assert ((sum == {WIDTH{~cin}}) && (cout == cin))
        else $error("full-propagate operands gave wrong result");
    end
  end

endmodule

// File: tb/test_cla_adder.sv
module test_cla_adder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 60000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [7:0]  a8, b8, s8;
  logic        c8, co8;

  cla_adder #(.WIDTH(16)) i_cla_adder (
    .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16)
  );

  cla_adder #(.WIDTH(8)) i_cla_adder_w8 (
    .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8)
  );

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run16(input string tag, input logic [15:0] x, input logic [15:0] y,
                       input logic ci);
    logic [16:0] exp;
    a16 = x; b16 = y; c16 = ci;
    #1;
    exp = {1'b0, x} + {1'b0, y} + {16'b0, ci};
    check(tag, {co16, s16}, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc >= WATCHDOG_CYCLES) begin
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a8  = '0; b8  = '0; c8  = 1'b0;

    // R6: zero inputs
    run16("R6 zero", 16'h0000, 16'h0000, 1'b0);
    // R2: extremes
    run16("R2 ones+ones+1", 16'hFFFF, 16'hFFFF, 1'b1);
    run16("R2 zero+zero+1", 16'h0000, 16'h0000, 1'b1);
    run16("R2 ones+ones+0", 16'hFFFF, 16'hFFFF, 1'b0);
    // R3: carry through every slice, and generated carry at each boundary
    run16("R3 ones+0+1", 16'hFFFF, 16'h0000, 1'b1);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] v;
      v = 16'h1 << (4 * k + 3);
      run16("R3 boundary", v, v, 1'b0);
      run16("R3 boundary cin", v, v, 1'b1);
    end
    // R4: full propagate patterns
    run16("R4 alt cin0", 16'hAAAA, 16'h5555, 1'b0);
    run16("R4 alt cin1", 16'hAAAA, 16'h5555, 1'b1);
    run16("R4 alt swap", 16'h5555, 16'hAAAA, 1'b1);
    for (int i = 0; i < 50; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      run16("R4 complement", r, ~r, i[0]);
    end
    // R1: random operands and alternating mixes
    run16("R1 alt same", 16'hAAAA, 16'hAAAA, 1'b1);
    run16("R1 alt same5", 16'h5555, 16'h5555, 1'b0);
    for (int i = 0; i < 2000; i++) begin
      run16("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));
    end

    // R5: exhaustive sweep of the 8-bit instance
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int ci = 0; ci < 2; ci++) begin
          logic [8:0] exp8;
          a8 = 8'(x); b8 = 8'(y); c8 = 1'(ci);
          #1;
          exp8 = 9'(x + y + ci);
          check("R5 exhaustive w8", {8'b0, co8, s8}, {8'b0, exp8});
        end
      end
    end

    finish_run();
  end

endmodule